// File: doc/BRIEF.md
# Twisted-Pair Crossover Selector

This block decides whether an Ethernet port's two twisted pairs are used straight or crossed. With the straight mapping the port transmits on pair A and receives on pair B. With the cross mapping it transmits on pair B and receives on pair A. The mapping is set in one of two ways. A management register can force it. Otherwise the block hunts for it: it toggles between the two mappings until the link detector reports a link.

Three configuration inputs choose the mode. The first is an enable pin that is pulled high on the board. The second is a register enable bit, and the third is a register manual-select bit. In automatic mode the mapping changes once every `DWELL_CYCLES` clock cycles for as long as there is no link. When a link is reported, the mapping is frozen and `resolved_o` rises. Auto-negotiation must wait for `resolved_o` before it starts. A change of effective mode restarts the selection from straight. All inputs are synchronous to `clk_i`.

Top module: `mdix_ctrl`

## Requirements
- R1: `cross_o` = 0 selects straight (transmit on pair A, receive on pair B). `cross_o` = 1 selects cross (transmit on pair B, receive on pair A).
- R2: While `rst_ni` is low, `cross_o` and `resolved_o` are both 0. Reset assumes pin = 1, register enable = 1 and manual bit = 0, which is automatic mode.
- R3: When `reg_auto_en_i` = 0, `cross_o` follows `reg_manual_cross_i` (0 gives straight, 1 gives cross), and `amdix_pin_i` has no effect.
- R4: When `reg_auto_en_i` = 1 and `amdix_pin_i` = 0, `cross_o` is 0, and `reg_manual_cross_i` has no effect.
- R5: When `reg_auto_en_i` = 1 and `amdix_pin_i` = 1, the block is in automatic mode.
- R6: In automatic mode with `link_up_i` low, `cross_o` inverts every `DWELL_CYCLES` cycles, and `resolved_o` is 0 from the cycle after link is sampled low.
- R7: In automatic mode, when `link_up_i` is sampled high, `resolved_o` is 1 on the next cycle and `cross_o` holds its value for as long as link stays high.
- R8: After link is lost, `resolved_o` falls on the next cycle. Toggling then resumes, and the first inversion comes a full `DWELL_CYCLES` cycles after the loss.
- R9: When the effective mode (straight, cross or automatic) changes, the next cycle shows `cross_o` = 0 and `resolved_o` = 0. A restart takes priority over a dwell expiry and over link in the same cycle.
- R10: In a forced mode, `resolved_o` is 1 from the second cycle in which the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| amdix_pin_i | input | 1 | Hardware enable for automatic selection |
| reg_auto_en_i | input | 1 | Register enable for automatic selection |
| reg_manual_cross_i | input | 1 | Register manual select, 1 = cross |
| link_up_i | input | 1 | Link status from the link detector |
| cross_o | output | 1 | Pair mapping, 0 = straight, 1 = cross |
| resolved_o | output | 1 | Mapping settled; auto-negotiation may start |

## Verification
Three events can fall in the same cycle: a mode restart, the expiry of the dwell timer, and a rising edge of link. The bench steps the automatic search until the timer is in its last dwell cycle. In that same cycle it either flips the enable pin or raises link. A cycle-accurate reference model gives the result: a restart beats both other events, and a link beats the expiry. Random segments with varying dwell phase also produce these coincidences at other points in the search.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  typedef enum logic [1:0] {
    MODE_STRAIGHT = 2'd0,
    MODE_CROSS    = 2'd1,
    MODE_AUTO     = 2'd2
  } mdix_mode_e;

  typedef struct packed {
    logic pin_en;
    logic reg_en;
    logic manual_cross;
  } mdix_cfg_t;

  localparam mdix_mode_e MODE_RESET = MODE_AUTO;
endpackage

// File: rtl/mdix_mode_dec.sv
module mdix_mode_dec
  import mdix_pkg::*;
(
  input  mdix_cfg_t  cfg_i,
  output mdix_mode_e mode_o
);
  always_comb begin
    if (!cfg_i.reg_en)
      mode_o = cfg_i.manual_cross ? MODE_CROSS : MODE_STRAIGHT;
    else if (!cfg_i.pin_en)
      mode_o = MODE_STRAIGHT;
    else
      mode_o = MODE_AUTO;
  end
endmodule

// File: rtl/mdix_mode_watch.sv
module mdix_mode_watch
  import mdix_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mdix_mode_e mode_i,
  output logic       changed_o
);
  mdix_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RESET;
    else         mode_q <= mode_i;
  end

  assign changed_o = (mode_i != mode_q);
endmodule

// File: rtl/mdix_dwell_timer.sv
module mdix_dwell_timer #(
  parameter int unsigned DWELL_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i || !run_i || expire_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdix_ctrl.sv
module mdix_ctrl
  import mdix_pkg::*;
#(
  parameter int unsigned DWELL_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic amdix_pin_i,
  input  logic reg_auto_en_i,
  input  logic reg_manual_cross_i,
  input  logic link_up_i,
  output logic cross_o,
  output logic resolved_o
);
  mdix_cfg_t  cfg;
  mdix_mode_e mode;
  logic       mode_chg;
  logic       search_run;
  logic       dwell_exp;
  logic       cross_q;
  logic       resolved_q;

  assign cfg = '{pin_en: amdix_pin_i, reg_en: reg_auto_en_i,
                 manual_cross: reg_manual_cross_i};

  mdix_mode_dec u_dec (
    .cfg_i  (cfg),
    .mode_o (mode)
  );

  mdix_mode_watch u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .changed_o (mode_chg)
  );

  assign search_run = (mode == MODE_AUTO) && !link_up_i;

  mdix_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (mode_chg),
    .run_i    (search_run),
    .expire_o (dwell_exp)
  );

  // restart outranks link and dwell expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cross_q    <= 1'b0;
      resolved_q <= 1'b0;
    end else if (mode_chg) begin
      cross_q    <= 1'b0;
      resolved_q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_STRAIGHT: begin cross_q <= 1'b0; resolved_q <= 1'b1; end
        MODE_CROSS:    begin cross_q <= 1'b1; resolved_q <= 1'b1; end
        default: begin
          resolved_q <= link_up_i;
          if (dwell_exp) cross_q <= ~cross_q;
        end
      endcase
    end
  end

  assign cross_o    = cross_q;
  assign resolved_o = resolved_q;
endmodule

// File: rtl/mdix_ctrl_chk.sv
module mdix_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic amdix_pin_i,
  input logic reg_auto_en_i,
  input logic reg_manual_cross_i,
  input logic link_up_i,
  input logic cross_o,
  input logic resolved_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      a_r2_reset_outputs: assert (!cross_o && !resolved_o);
    end
  end

  a_r3_manual_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !reg_auto_en_i && $stable(reg_auto_en_i) && $stable(reg_manual_cross_i)
    |=> (cross_o == $past(reg_manual_cross_i)) && resolved_o);

  a_r4_pin_low_straight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && reg_auto_en_i && !amdix_pin_i && $stable(reg_auto_en_i) && $stable(amdix_pin_i)
    |=> !cross_o && resolved_o);

  a_r7_link_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && reg_auto_en_i && amdix_pin_i && $stable(reg_auto_en_i) && $stable(amdix_pin_i)
    && link_up_i |=> resolved_o && $stable(cross_o));

  a_r6_no_link_unresolved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_auto_en_i && amdix_pin_i && !link_up_i |=> !resolved_o);

  a_r9_restart_straight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && reg_auto_en_i && $stable(reg_auto_en_i) && $changed(amdix_pin_i)
    |=> !cross_o && !resolved_o);
endmodule

bind mdix_ctrl mdix_ctrl_chk u_chk (.*);

// File: tb/mdix_ctrl_tb.sv
module mdix_ctrl_tb_top;
  localparam int D = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic amdix_pin_i = 1'b1;
  logic reg_auto_en_i = 1'b1;
  logic reg_manual_cross_i = 1'b0;
  logic link_up_i = 1'b0;
  logic cross_o, resolved_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int   m_mode = 2;
  int   m_cnt = 0;
  logic m_cross = 1'b0;
  logic m_res = 1'b0;
  logic m_link_q = 1'b0;
  string m_tag = "";

  always #5 clk_i = ~clk_i;

  mdix_ctrl #(.DWELL_CYCLES(D)) dut_i (
    .clk_i, .rst_ni, .amdix_pin_i, .reg_auto_en_i,
    .reg_manual_cross_i, .link_up_i, .cross_o, .resolved_o
  );

  // 0 straight, 1 cross, 2 auto
  function automatic int mode_of(logic p, logic e, logic m);
    if (!e) return m ? 1 : 0;
    if (!p) return 0;
    return 2;
  endfunction

  function automatic void model_step(logic p, logic e, logic m, logic l);
    int nm = mode_of(p, e, m);
    if (nm != m_mode) begin
      m_cross = 1'b0; m_res = 1'b0; m_cnt = 0; m_tag = "R9";
    end else if (nm == 0) begin
      m_cross = 1'b0; m_res = 1'b1; m_cnt = 0;
      m_tag = e ? "R4 R10" : "R1 R3 R10";
    end else if (nm == 1) begin
      m_cross = 1'b1; m_res = 1'b1; m_cnt = 0; m_tag = "R1 R3 R10";
    end else if (l) begin
      m_res = 1'b1; m_cnt = 0; m_tag = "R5 R7";
    end else begin
      m_res = 1'b0;
      m_tag = m_link_q ? "R8" : "R5 R6";
      if (m_cnt == D - 1) begin m_cross = ~m_cross; m_cnt = 0; end
      else m_cnt++;
    end
    m_mode = nm;
    m_link_q = l;
  endfunction

  function automatic void check(string tag, logic c, logic r, logic ec, logic er);
    n_chk++;
    if (c !== ec || r !== er) begin
      n_bad++;
      $display("FAIL %s cross=%0b exp %0b resolved=%0b exp %0b", tag, c, ec, r, er);
    end
  endfunction

  task automatic step(logic p, logic e, logic m, logic l);
    amdix_pin_i = p; reg_auto_en_i = e; reg_manual_cross_i = m; link_up_i = l;
    @(posedge clk_i);
    model_step(p, e, m, l);
    @(negedge clk_i);
    check(m_tag, cross_o, resolved_o, m_cross, m_res);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog cross=%0b exp - resolved=%0b exp -", cross_o, resolved_o);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1894));
    repeat (3) @(negedge clk_i);
    check("R2", cross_o, resolved_o, 1'b0, 1'b0);
    rst_ni = 1'b1;

    // R5 R6: default auto search toggles per dwell
    for (int i = 0; i < 3 * D; i++) step(1, 1, 0, 0);
    // R7: link freezes, manual bit ignored in auto
    for (int i = 0; i < 5; i++) step(1, 1, i[0], 1);
    // R8: link loss resumes after full dwell
    for (int i = 0; i < 2 * D; i++) step(1, 1, 0, 0);
    // R3: manual cross, pin toggled has no effect
    for (int i = 0; i < 6; i++) step(i[1], 0, 1, i[0]);
    // R1 R3: manual straight
    for (int i = 0; i < 4; i++) step(i[0], 0, 0, 0);
    // R4: pin low forces straight, manual bit ignored
    for (int i = 0; i < 6; i++) step(0, 1, i[1], i[0]);

    // R9 collision: restart in the expiry cycle
    step(1, 1, 0, 0);
    while (m_cnt != D - 1) step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    // R7 collision: link in expiry cycle beats toggle
    step(1, 1, 0, 0);
    while (m_cnt != D - 1) step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    step(1, 1, 0, 1);

    // random segments
    for (int s = 0; s < 400; s++) begin
      logic p, e, m, l;
      int len;
      p = ($urandom_range(0, 4) != 0);
      e = ($urandom_range(0, 4) != 0);
      m = $urandom_range(0, 1);
      l = $urandom_range(0, 1);
      len = $urandom_range(1, 3 * D);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 7) == 0) l = ~l;
        if ($urandom_range(0, 15) == 0) m = ~m;
        step(p, e, m, l);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule